// File: doc/BRIEF.md
# Frame-Synchronised Serial Word Receiver

This block turns a continuous serial bit stream into bytes. A free-running bit clock, which is also the design clock, samples one data line and one frame-sync line on the same rising edge. A sync pulse lasts exactly one cycle and marks the cycle just before the first bit of a 16-bit word. The bit that arrives in the sync cycle itself is not part of the word. The next 16 bits are collected MSB first and handed out as two bytes on a valid/ready byte port, upper half first. Bits that arrive when no word is expected are thrown away.

Words may follow each other with no gap. In that case the sync for the next word shares a cycle with the 16th bit of the current word, and both are handled in that cycle. A sync that comes earlier, while a word is still only partly received, drops the partial word, reports a framing error and aligns to the new word. If the downstream side has not taken the previous byte when a new byte is ready, a sticky overflow flag is set and the new byte is dropped.

The control is a two-state machine. In `ST_IDLE` no word is expected and bits are discarded. In `ST_RECV` a word is being collected. The transitions are:
- IDLE→RECV on a sync (arm).
- RECV→RECV with the count cleared, in two cases: a sync on the 16th bit (chain), or a sync before the 16th bit (restart, which raises the framing error).
- RECV→IDLE on the 16th bit when there is no sync (done).
- Otherwise RECV stays in RECV and the count advances (advance).

Top module: `fsync_word_rx`

## Requirements
- R1: When synchronous reset is applied, the block clears `byte_valid`, `overflow` and `frame_err` and discards any word in progress.
- R2: The data bit sampled in the same cycle as a sync pulse is discarded. The next 16 sampled bits form the word, and the first of them is the word's most significant bit (bit 15).
- R3: The first byte is bits 15..8 of the word and goes valid the cycle after the 8th data bit is sampled. The second byte is bits 7..0 and goes valid the cycle after the 16th data bit.
- R4: When a sync coincides with the 16th data bit of the current word, both bytes of the current word are delivered. The next word is aligned to that sync with no lost or shifted bit, and `frame_err` stays low.
- R5: Bits sampled while no word is expected (no sync since the last word completed) never produce a byte.
- R6: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` does not change. A byte is taken on a clock edge where both are high.
- R7: If a new byte completes while the held byte is still untaken, the new byte is dropped, the held byte is kept, and `overflow` goes high and stays high until reset.
- R8: A sync that arrives before the 16th data bit of the word in progress produces a one-cycle `frame_err` pulse in the next cycle. The bits of the partial word that have not already been delivered as a byte are discarded, and reception realigns to the new sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, also the design clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data bit |
| ser_sync | input | 1 | Frame-sync pulse, one cycle ahead of the word |
| byte_data | output | 8 | Received byte |
| byte_valid | output | 1 | `byte_data` holds an untaken byte |
| byte_ready | input | 1 | Downstream accepts the byte |
| overflow | output | 1 | Sticky flag: a byte was dropped |
| frame_err | output | 1 | One-cycle pulse on a mid-word sync |

## Verification
The bound checker watches the port-level rules on every cycle:
- the reset state;
- the byte held stable while it waits for ready;
- overflow being sticky and rising only when a byte is waiting untaken;
- a framing-error pulse appearing only in the cycle after a sync.

Bit alignment itself can only be shown by the bench's scenarios, which compare the delivered bytes against a queue of expected bytes. These scenarios are chained words with the overlapping sync, isolated words, idle noise, a mid-word restart and a stalled consumer. Together they show that no one-bit shift appears and that idle or abandoned bits never reach the output.

// File: rtl/fsync_rx_pkg.sv
package fsync_rx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;
endpackage

// File: rtl/fsync_rx_ctrl.sv
module fsync_rx_ctrl #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic take_bit,
    output logic emit,
    output logic frame_err
);
    import fsync_rx_pkg::*;

    localparam int CNT_W = $clog2(WORD_W);
    localparam int SUB_W = $clog2(BYTE_W);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             last_bit;
    logic             restart;

    assign last_bit = (cnt == CNT_W'(WORD_W - 1));

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sync_in) begin       // arm
                        state <= ST_RECV;
                        cnt   <= '0;
                    end
                end
                ST_RECV: begin
                    if (sync_in) begin       // chain or restart
                        state <= ST_RECV;
                        cnt   <= '0;
                    end else if (last_bit) begin  // done
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin           // advance
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        take_bit = 1'b0;
        restart  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                take_bit = 1'b0;
            end
            ST_RECV: begin
                restart  = sync_in && !last_bit;
                take_bit = !restart;
            end
        endcase
        emit = take_bit && (cnt[SUB_W-1:0] == {SUB_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst) frame_err <= 1'b0;
        else     frame_err <= restart;
    end
endmodule

// File: rtl/fsync_rx_shift.sv
module fsync_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_bit,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] next_byte
);
    logic [BYTE_W-2:0] hist;

    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (take_bit) hist <= {hist[BYTE_W-3:0], bit_in};
    end

    assign next_byte = {hist, bit_in};
endmodule

// File: rtl/fsync_rx_outreg.sv
module fsync_rx_outreg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic [BYTE_W-1:0] next_byte,
    input  logic              ready,
    output logic [BYTE_W-1:0] data,
    output logic              valid,
    output logic              ovf
);
    logic slot_free;

    assign slot_free = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (valid && ready) valid <= 1'b0;
            if (emit) begin
                if (slot_free) begin
                    data  <= next_byte;
                    valid <= 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fsync_word_rx.sv
module fsync_word_rx #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_data,
    input  logic              ser_sync,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic              overflow,
    output logic              frame_err
);
    logic              take_bit;
    logic              emit;
    logic [BYTE_W-1:0] next_byte;

    fsync_rx_ctrl #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (ser_sync),
        .take_bit  (take_bit),
        .emit      (emit),
        .frame_err (frame_err)
    );

    fsync_rx_shift #(.BYTE_W(BYTE_W)) i_shift (
        .clk       (clk),
        .rst       (rst),
        .take_bit  (take_bit),
        .bit_in    (ser_data),
        .next_byte (next_byte)
    );

    fsync_rx_outreg #(.BYTE_W(BYTE_W)) i_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .next_byte (next_byte),
        .ready     (byte_ready),
        .data      (byte_data),
        .valid     (byte_valid),
        .ovf       (overflow)
    );
endmodule

// File: rtl/fsync_rx_checker.sv
module fsync_rx_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_sync,
    input logic [BYTE_W-1:0] byte_data,
    input logic              byte_valid,
    input logic              byte_ready,
    input logic              overflow,
    input logic              frame_err
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!byte_valid && !overflow && !frame_err));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r7_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(byte_valid && !byte_ready));

    a_r8_after_sync: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(ser_sync));
endmodule

bind fsync_word_rx fsync_rx_checker #(.BYTE_W(BYTE_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_sync   (ser_sync),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .overflow   (overflow),
    .frame_err  (frame_err)
);

// File: tb/test_fsync_word_rx.sv
module test_fsync_word_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_data = 1'b0;
    logic       ser_sync = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic       byte_ready = 1'b1;
    logic       overflow;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int fe_count = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    fsync_word_rx i_fsync_word_rx (
        .clk        (clk),
        .rst        (rst),
        .ser_data   (ser_data),
        .ser_sync   (ser_sync),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .overflow   (overflow),
        .frame_err  (frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design hands them over
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && frame_err) fe_count++;
            if (!rst && byte_valid && byte_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected byte", int'(byte_data), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(byte_data == e, "R2/R3/R4 byte value", int'(byte_data), int'(e));
                end
            end
        end
    end

    task automatic drive_cycle(input logic s, input logic d);
        @(negedge clk);
        ser_sync = s;
        ser_data = d;
    endtask

    task automatic send_burst(input logic [15:0] w[$], input bit push_exp);
        if (push_exp) begin
            foreach (w[i]) begin
                exp_q.push_back(w[i][15:8]);
                exp_q.push_back(w[i][7:0]);
            end
        end
        drive_cycle(1'b1, 1'($urandom));   // R2: bit in sync cycle is junk
        foreach (w[i]) begin
            for (int b = 0; b < 16; b++) begin
                drive_cycle((b == 15) && (i < w.size() - 1), w[i][15 - b]);
            end
        end
        drive_cycle(1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive_cycle(1'b0, 1'($urandom));
    endtask

    task automatic drain_check(input string req);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        logic [15:0] ws[$];
        int fe_before;
        repeat (3) @(negedge clk);
        #1;
        check(!byte_valid, "R1 valid after reset", byte_valid, 0);
        check(!overflow,   "R1 overflow after reset", overflow, 0);
        check(!frame_err,  "R1 frame_err after reset", frame_err, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: single word
        ws = '{16'hA53C};
        send_burst(ws, 1'b1);
        drain_check("R3 single word delivered");

        // R4: back-to-back alternating patterns, sync overlapping 16th bit
        ws = '{16'hF0F0, 16'hF0F0, 16'h8787, 16'h0F0F, 16'h5555, 16'hAAAA, 16'h8001, 16'h7FFE};
        send_burst(ws, 1'b1);
        drain_check("R4 chained words delivered");
        check(fe_count == 0, "R4 no frame_err on chained sync", fe_count, 0);

        // R5: idle noise gives no byte
        idle(40);
        drain_check("R5 idle noise");
        check(!byte_valid, "R5 nothing valid after noise", byte_valid, 0);

        // R2: separated words with gaps
        ws = '{16'h1234};
        send_burst(ws, 1'b1);
        idle(7);
        ws = '{16'hCAFE};
        send_burst(ws, 1'b1);
        drain_check("R2 gapped words");

        // R8: mid-word sync restarts alignment
        fe_before = fe_count;
        drive_cycle(1'b1, 1'b1);
        idle(5);
        ws = '{16'h3C69};
        send_burst(ws, 1'b1);
        drain_check("R8 realigned word");
        check(fe_count == fe_before + 1, "R8 one frame_err pulse", fe_count, fe_before + 1);

        // R6/R7: stalled consumer
        check(!overflow, "R7 overflow low before stall", overflow, 0);
        @(negedge clk);
        byte_ready = 1'b0;
        ws = '{16'h9E42};
        exp_q.push_back(8'h9E);
        send_burst(ws, 1'b0);
        @(negedge clk);
        #1;
        check(byte_valid, "R6 byte held while not ready", byte_valid, 1);
        check(byte_data == 8'h9E, "R7 held byte kept", byte_data, 8'h9E);
        check(overflow, "R7 overflow set", overflow, 1);
        @(negedge clk);
        byte_ready = 1'b1;
        drain_check("R7 only held byte delivered");
        check(overflow, "R7 overflow sticky", overflow, 1);

        // R1: reset again, word in progress discarded
        drive_cycle(1'b1, 1'b0);
        idle(4);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!overflow, "R1 overflow cleared", overflow, 0);
        check(!byte_valid, "R1 valid cleared", byte_valid, 0);
        rst = 1'b0;
        idle(20);
        drain_check("R1 no byte from aborted word");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule